// File: doc/BRIEF.md
# Rotating-priority interrupt controller

This block arbitrates eight interrupt request lines for a CPU. Each cycle it picks the highest-priority pending request that is not masked. It raises `int_o` when that request outranks every level already in service. A two-pulse acknowledge sequence then records the winner in an in-service register and hands the CPU a vector. The vector is a programmable base with the winning level in its low three bits.

The priority order is a circle with a movable bottom. At reset level 0 is highest and level 7 is lowest. Software can rotate the order so that a serviced level drops to the bottom, or it can name the bottom level directly. End of interrupt can be issued as a non-specific command, as a specific command, or as a command combined with a rotation. It can also happen automatically at the second acknowledge pulse. A special-mask-mode input changes how masked in-service levels are treated.

Command word layout used throughout: bit 7 = rotate flag, bit 6 = select-level flag, bit 5 = end-of-interrupt flag, bits 4:3 = reserved (must be 00), bits 2:0 = level.

Top module: `irq_rotor`

## Requirements
- R1: After reset the in-service register and mask are clear, the bottom level is 7 (level 0 highest, level 7 lowest), rotate-on-auto-EOI is off, and `int_o` is low with no requests.
- R2: `int_o` is high in the same cycle exactly when an unmasked request exists whose priority is above every counted in-service level. Requests of the same or lower priority than a counted in-service level do not raise it.
- R3: Mask bit i blocks request line i only; the other lines behave as if the mask were clear.
- R4: On the first `ack_i` cycle with `int_o` high, the winning level's in-service bit is set and `{vec_base_i, level}` is latched. During the second `ack_i` cycle, `vec_valid_o` is high and `vec_o` shows that value.
- R5: If `int_o` is low on the first acknowledge, the vector carries level 7 and no in-service bit is set.
- R6: Command 0x20 (non-specific EOI) clears the highest-priority counted in-service bit, visible from the next cycle.
- R7: Command 0x60|L (specific EOI) clears in-service bit L only; naming a clear bit changes nothing.
- R8: While `spec_mask_i` is high, in-service bits whose mask bit is set neither block requests nor get cleared by a non-specific EOI.
- R9: With `auto_eoi_i` high, the second acknowledge cycle performs a non-specific EOI, visible from the next cycle.
- R10: Command 0xA0 clears the highest counted in-service bit and makes that level the bottom priority; with level 4 serviced, level 5 becomes highest.
- R11: Command 0x80 sets the rotate-on-auto-EOI flag and 0x00 clears it. While it is set, each automatic EOI also makes the serviced level the bottom priority.
- R12: Command 0xC0|L makes level L the bottom priority (level L+1 mod 8 highest). Command 0xE0|L clears in-service bit L and makes L the bottom priority.
- R13: Command 0x40|L has no effect, and any command with bits 4:3 not equal to 00 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 8 | Interrupt request lines, level sensitive |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 8 | Mask register write data, bit i masks line i |
| cmd_we_i | input | 1 | Command word strobe |
| cmd_i | input | 8 | Command word |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt enable |
| spec_mask_i | input | 1 | Special mask mode enable |
| vec_base_i | input | 5 | Vector base, upper five bits |
| ack_i | input | 1 | Acknowledge pulse, one cycle per pulse, two pulses per sequence |
| int_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Latched vector |
| vec_valid_o | output | 1 | High while `vec_o` is being delivered (second acknowledge) |

## Verification
`int_o` is combinational from the request lines and the registered state. The bench therefore drives each stimulus on a falling edge and samples `int_o` one nanosecond later, in the same cycle. Mask writes, commands and in-service updates take effect at the next rising edge, so their effect is sampled at the following falling edge. The vector is latched at the edge that ends the first acknowledge cycle and is shown combinationally during the second. The scoreboard monitor compares it 2 ns after the falling edge that starts that cycle. Automatic EOI and any rotation it causes are observed from the falling edge after the second acknowledge.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;

  typedef struct packed {
    logic       rot;
    logic       sel;
    logic       eoi;
    logic [1:0] rsvd;
    logic [2:0] lvl;
  } cmd_t;

  typedef enum logic [2:0] {
    OP_CLR_RAEOI = 3'b000,
    OP_NS_EOI    = 3'b001,
    OP_NOP       = 3'b010,
    OP_SP_EOI    = 3'b011,
    OP_SET_RAEOI = 3'b100,
    OP_ROT_NS    = 3'b101,
    OP_SET_PRI   = 3'b110,
    OP_ROT_SP    = 3'b111
  } op_e;

endpackage

// File: rtl/irq_rotor_resolver.sv
// Finds the highest-priority set bit given a movable bottom level.
module irq_rotor_resolver #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] vec_i,
  input  logic [LVL_W-1:0]   bottom_i,
  output logic               found_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [LVL_W-1:0]   rank_o
);

  logic [LVL_W-1:0]   start;
  logic [NUM_LVL-1:0] rot;

  assign start = bottom_i + LVL_W'(1);

  // rot[0] is the highest-priority level
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_rot
    logic [LVL_W-1:0] src;
    assign src    = start + LVL_W'(g);
    assign rot[g] = vec_i[src];
  end

  always_comb begin
    found_o = 1'b0;
    rank_o  = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (rot[i]) begin
        found_o = 1'b1;
        rank_o  = LVL_W'(i);
      end
    end
  end

  assign lvl_o = rank_o + start;

endmodule

// File: rtl/irq_rotor_ctrl.sv
// Mask, in-service register, priority bottom and command decode.
module irq_rotor_ctrl import irq_rotor_pkg::*; #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_LVL-1:0] mask_data_i,
  input  logic               cmd_we_i,
  input  logic [7:0]         cmd_i,
  input  logic               set_en_i,
  input  logic [LVL_W-1:0]   set_lvl_i,
  input  logic               aeoi_fire_i,
  input  logic               eoi_found_i,
  input  logic [LVL_W-1:0]   eoi_lvl_i,
  output logic [NUM_LVL-1:0] mask_q,
  output logic [NUM_LVL-1:0] isr_q,
  output logic [LVL_W-1:0]   bottom_q,
  output logic               rot_aeoi_q
);

  cmd_t             cmd;
  op_e              op;
  logic             cmd_ok;
  logic [LVL_W-1:0] cmd_lvl;

  logic [NUM_LVL-1:0] set_vec, clr_vec;
  logic [LVL_W-1:0]   bottom_n;
  logic               rot_aeoi_n;

  assign cmd     = cmd_t'(cmd_i);
  assign op      = op_e'({cmd.rot, cmd.sel, cmd.eoi});
  assign cmd_ok  = cmd_we_i && (cmd.rsvd == 2'b00);
  assign cmd_lvl = LVL_W'(cmd.lvl);

  always_comb begin
    set_vec    = '0;
    clr_vec    = '0;
    bottom_n   = bottom_q;
    rot_aeoi_n = rot_aeoi_q;

    if (set_en_i) set_vec[set_lvl_i] = 1'b1;

    if (aeoi_fire_i && eoi_found_i) begin
      clr_vec[eoi_lvl_i] = 1'b1;
      if (rot_aeoi_q) bottom_n = eoi_lvl_i;
    end

    // command wins over automatic rotation for the bottom level
    if (cmd_ok) begin
      unique case (op)
        OP_CLR_RAEOI: rot_aeoi_n = 1'b0;
        OP_SET_RAEOI: rot_aeoi_n = 1'b1;
        OP_NS_EOI: if (eoi_found_i) clr_vec[eoi_lvl_i] = 1'b1;
        OP_SP_EOI: clr_vec[cmd_lvl] = 1'b1;
        OP_ROT_NS: begin
          if (eoi_found_i) begin
            clr_vec[eoi_lvl_i] = 1'b1;
            bottom_n           = eoi_lvl_i;
          end
        end
        OP_SET_PRI: bottom_n = cmd_lvl;
        OP_ROT_SP: begin
          clr_vec[cmd_lvl] = 1'b1;
          bottom_n         = cmd_lvl;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      isr_q      <= '0;
      bottom_q   <= LVL_W'(NUM_LVL - 1);
      rot_aeoi_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i;
      isr_q      <= (isr_q | set_vec) & ~clr_vec;
      bottom_q   <= bottom_n;
      rot_aeoi_q <= rot_aeoi_n;
    end
  end

endmodule

// File: rtl/irq_rotor_ack.sv
// Two-pulse acknowledge sequencer and vector latch.
module irq_rotor_ack #(
  parameter int LVL_W  = 3,
  parameter int BASE_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ack_i,
  input  logic                    int_i,
  input  logic [LVL_W-1:0]        win_lvl_i,
  input  logic [BASE_W-1:0]       base_i,
  input  logic                    auto_eoi_i,
  output logic                    phase_q,
  output logic                    set_en_o,
  output logic [LVL_W-1:0]        set_lvl_o,
  output logic                    aeoi_fire_o,
  output logic [BASE_W+LVL_W-1:0] vec_o,
  output logic                    vec_valid_o
);

  logic first, second;
  logic [BASE_W+LVL_W-1:0] vec_q;

  assign first  = ack_i & ~phase_q;
  assign second = ack_i & phase_q;

  assign set_en_o    = first & int_i;
  assign set_lvl_o   = win_lvl_i;
  assign aeoi_fire_o = second & auto_eoi_i;
  assign vec_o       = vec_q;
  assign vec_valid_o = second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (first) begin
        phase_q <= 1'b1;
        vec_q   <= {base_i, int_i ? win_lvl_i : {LVL_W{1'b1}}};
      end else if (second) begin
        phase_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_rotor.sv
module irq_rotor #(
  parameter int NUM_LVL = 8,
  parameter int VEC_W   = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LVL-1:0]                irq_req_i,
  input  logic                              mask_we_i,
  input  logic [NUM_LVL-1:0]                mask_data_i,
  input  logic                              cmd_we_i,
  input  logic [7:0]                        cmd_i,
  input  logic                              auto_eoi_i,
  input  logic                              spec_mask_i,
  input  logic [VEC_W-$clog2(NUM_LVL)-1:0]  vec_base_i,
  input  logic                              ack_i,
  output logic                              int_o,
  output logic [VEC_W-1:0]                  vec_o,
  output logic                              vec_valid_o
);

  localparam int LVL_W  = $clog2(NUM_LVL);
  localparam int BASE_W = VEC_W - LVL_W;

  logic [NUM_LVL-1:0] mask_q, isr_q, pend, isr_eff;
  logic [LVL_W-1:0]   bottom_q;
  logic               rot_aeoi_q;

  logic             p_found, s_found;
  logic [LVL_W-1:0] p_lvl, p_rank, s_lvl, s_rank;

  logic             phase_q, set_en, aeoi_fire;
  logic [LVL_W-1:0] set_lvl;

  assign pend    = irq_req_i & ~mask_q;
  // special mask mode hides masked in-service levels
  assign isr_eff = spec_mask_i ? (isr_q & ~mask_q) : isr_q;

  irq_rotor_resolver #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_req_res (
    .vec_i    (pend),
    .bottom_i (bottom_q),
    .found_o  (p_found),
    .lvl_o    (p_lvl),
    .rank_o   (p_rank)
  );

  irq_rotor_resolver #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_isr_res (
    .vec_i    (isr_eff),
    .bottom_i (bottom_q),
    .found_o  (s_found),
    .lvl_o    (s_lvl),
    .rank_o   (s_rank)
  );

  assign int_o = p_found & (~s_found | (p_rank < s_rank));

  irq_rotor_ctrl #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we_i),
    .mask_data_i (mask_data_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_i       (cmd_i),
    .set_en_i    (set_en),
    .set_lvl_i   (set_lvl),
    .aeoi_fire_i (aeoi_fire),
    .eoi_found_i (s_found),
    .eoi_lvl_i   (s_lvl),
    .mask_q      (mask_q),
    .isr_q       (isr_q),
    .bottom_q    (bottom_q),
    .rot_aeoi_q  (rot_aeoi_q)
  );

  irq_rotor_ack #(.LVL_W(LVL_W), .BASE_W(BASE_W)) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .int_i       (int_o),
    .win_lvl_i   (p_lvl),
    .base_i      (vec_base_i),
    .auto_eoi_i  (auto_eoi_i),
    .phase_q     (phase_q),
    .set_en_o    (set_en),
    .set_lvl_o   (set_lvl),
    .aeoi_fire_o (aeoi_fire),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

endmodule

// File: rtl/irq_rotor_chk.sv
module irq_rotor_chk #(
  parameter int NUM_LVL = 8,
  parameter int BASE_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               cmd_we_i,
  input logic [7:0]         cmd_i,
  input logic               int_o,
  input logic [NUM_LVL-1:0] irq_req_i,
  input logic [NUM_LVL-1:0] mask_q,
  input logic [NUM_LVL-1:0] isr_q,
  input logic               phase_q,
  input logic [BASE_W-1:0]  vec_hi,
  input logic [BASE_W-1:0]  vec_base_i
);

  assert_int_needs_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irq_req_i & ~mask_q) != '0));

  assert_ack_sets_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !phase_q && int_o && !cmd_we_i) |=>
      ($countones(isr_q) == $countones($past(isr_q)) + 1));

  assert_vec_base_latched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !phase_q) |=> (phase_q && (vec_hi == $past(vec_base_i))));

  assert_seq_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && phase_q) |=> !phase_q);

  assert_idle_ack_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !phase_q && !int_o) |=> ((isr_q & ~$past(isr_q)) == '0));

  assert_eoi_never_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[5] && !(ack_i && !phase_q)) |=> ((isr_q & ~$past(isr_q)) == '0));

endmodule

bind irq_rotor irq_rotor_chk #(.NUM_LVL(NUM_LVL), .BASE_W(VEC_W - $clog2(NUM_LVL))) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .cmd_we_i   (cmd_we_i),
  .cmd_i      (cmd_i),
  .int_o      (int_o),
  .irq_req_i  (irq_req_i),
  .mask_q     (mask_q),
  .isr_q      (isr_q),
  .phase_q    (phase_q),
  .vec_hi     (vec_o[VEC_W-1:$clog2(NUM_LVL)]),
  .vec_base_i (vec_base_i)
);

// File: tb/irq_rotor_bench.sv
`timescale 1ns/1ps
module irq_rotor_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq_req_i = '0;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_data_i = '0;
  logic       cmd_we_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic       auto_eoi_i = 1'b0;
  logic       spec_mask_i = 1'b0;
  logic [4:0] vec_base_i = 5'b10101;
  logic       ack_i = 1'b0;
  logic       int_o;
  logic [7:0] vec_o;
  logic       vec_valid_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  irq_rotor u_irq_rotor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_req_i   (irq_req_i),
    .mask_we_i   (mask_we_i),
    .mask_data_i (mask_data_i),
    .cmd_we_i    (cmd_we_i),
    .cmd_i       (cmd_i),
    .auto_eoi_i  (auto_eoi_i),
    .spec_mask_i (spec_mask_i),
    .vec_base_i  (vec_base_i),
    .ack_i       (ack_i),
    .int_o       (int_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (vec_valid_o) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL R4 unexpected vector: actual %h expected none", vec_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (vec_o !== e) begin
            n_err++;
            $display("FAIL %s vector: actual %h expected %h", t, vec_o, e);
          end
        end
      end
    end
  end

  task automatic chk_int(input logic exp, input string tag);
    #1;
    n_chk++;
    if (int_o !== exp) begin
      n_err++;
      $display("FAIL %s int_o: actual %b expected %b", tag, int_o, exp);
    end
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk_i);
    irq_req_i = v;
  endtask

  task automatic do_cmd(input logic [7:0] v);
    @(negedge clk_i);
    cmd_we_i = 1'b1;
    cmd_i    = v;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic do_mask(input logic [7:0] v);
    @(negedge clk_i);
    mask_we_i   = 1'b1;
    mask_data_i = v;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  // driver: pushes expected vector, runs both acknowledge pulses
  task automatic ack_pair(input logic [2:0] lvl, input string tag);
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    exp_q.push_back({vec_base_i, lvl});
    tag_q.push_back(tag);
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state and default order
    set_req(8'h00); chk_int(1'b0, "R1");
    set_req(8'h90); chk_int(1'b1, "R1");
    ack_pair(3'd4, "R1");
    // R2 nesting
    chk_int(1'b0, "R2");
    set_req(8'h94); chk_int(1'b1, "R2");
    ack_pair(3'd2, "R2");
    set_req(8'h10); chk_int(1'b0, "R2");
    // R6 non-specific EOI clears 2 first, then 4
    do_cmd(8'h20); chk_int(1'b0, "R6");
    set_req(8'h08); chk_int(1'b1, "R6");
    do_cmd(8'h20);
    set_req(8'h10); chk_int(1'b1, "R6");
    // R3 masking
    do_mask(8'h10); chk_int(1'b0, "R3");
    set_req(8'h11); chk_int(1'b1, "R3");
    ack_pair(3'd0, "R3");
    do_mask(8'h00);
    // R7 specific EOI
    set_req(8'h10); chk_int(1'b0, "R7");
    do_cmd(8'h64); chk_int(1'b0, "R7");
    do_cmd(8'h60); chk_int(1'b1, "R7");
    // R5 acknowledge with nothing pending
    set_req(8'h00); chk_int(1'b0, "R5");
    ack_pair(3'd7, "R5");
    set_req(8'h80); chk_int(1'b1, "R5");
    // R13 no-op and reserved bits
    ack_pair(3'd7, "R13");
    chk_int(1'b0, "R13");
    do_cmd(8'h47); chk_int(1'b0, "R13");
    do_cmd(8'h7F); chk_int(1'b0, "R13");
    do_cmd(8'h67); chk_int(1'b1, "R7");
    // R10 rotate on non-specific EOI
    set_req(8'h10);
    ack_pair(3'd4, "R10");
    do_cmd(8'hA0);
    set_req(8'h21); chk_int(1'b1, "R10");
    ack_pair(3'd5, "R10");
    do_cmd(8'h20);
    // R12 set priority and rotate on specific EOI
    do_cmd(8'hC5);
    set_req(8'h41);
    ack_pair(3'd6, "R12");
    do_cmd(8'hE6);
    set_req(8'h81); chk_int(1'b1, "R12");
    ack_pair(3'd7, "R12");
    do_cmd(8'h20);
    do_cmd(8'hC7);
    // R9 auto EOI
    auto_eoi_i = 1'b1;
    set_req(8'h04);
    ack_pair(3'd2, "R9");
    chk_int(1'b1, "R9");
    // R11 rotate on auto EOI
    do_cmd(8'h80);
    set_req(8'h09);
    ack_pair(3'd0, "R11");
    ack_pair(3'd3, "R11");
    set_req(8'h11);
    ack_pair(3'd4, "R11");
    do_cmd(8'h00);
    ack_pair(3'd0, "R11");
    ack_pair(3'd0, "R11");
    auto_eoi_i = 1'b0;
    do_cmd(8'hC7);
    // R8 special mask mode
    set_req(8'h04);
    ack_pair(3'd2, "R8");
    set_req(8'h01);
    ack_pair(3'd0, "R8");
    spec_mask_i = 1'b1;
    do_mask(8'h01);
    set_req(8'h08); chk_int(1'b0, "R8");
    do_cmd(8'h20); chk_int(1'b1, "R8");
    spec_mask_i = 1'b0;
    do_mask(8'h00); chk_int(1'b0, "R8");
    do_cmd(8'h20); chk_int(1'b1, "R8");

    repeat (3) @(negedge clk_i);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R4 vectors outstanding: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule